// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch and Add Unit

This unit carries out the operand half of a two-operand add. It finds the second source value under one of ten addressing modes and fetches it. It then adds that value to the destination register and writes the sum back. A controller presents a mode code, three register indices, a 16-bit constant and an element-size code, then pulses `start`. The unit then drives three combinational register-file read ports, one register-file write port and a single-port synchronous memory read port. The memory returns data one cycle after a read is issued.

Each memory access takes its own cycle. The mode decides the sequence of accesses and base-register updates. Memory-indirect mode chains two reads. Auto-increment mode reads first and then bumps the base register. Auto-decrement mode lowers the base register first and then reads through it. Scaled mode adds a shifted index to the constant and the base. A one-cycle `done` pulse ends every operation. An undefined mode code ends with `err` and writes nothing.

Top module: `addr_mode_adder`

## Requirements
- R1: Mode 0 (register) takes the base register value as the operand, and mode 1 (immediate) takes `imm` as the operand. Neither mode asserts `mem_re`, and `done` rises 3 clock edges after the edge that samples `start`, counting that edge.
- R2: Mode 2 (displacement) reads memory at `imm` + base, and mode 3 (register indirect) reads memory at base. With base 100, `imm` 200, Mem[300]=600 and Mem[100]=400, they add 600 and 400 respectively.
- R3: Mode 4 (indexed) reads memory at base + index register, and mode 5 (direct) reads memory at `imm`.
- R4: Mode 6 (memory indirect) issues exactly two reads. The first read uses base as its address. The data it returns is the address of the second read, which supplies the operand. `done` rises 5 edges after the start edge.
- R5: Mode 7 (auto-increment) reads at the current base and then writes base + d to the base register, where d = 1 << `esize` (`esize` 0..3 gives d = 1, 2, 4, 8). `done` rises 5 edges after the start edge.
- R6: Mode 8 (auto-decrement) first writes base − d to the base register and then reads at the lowered value. `done` rises 6 edges after the start edge.
- R7: Mode 9 (scaled) reads memory at `imm` + base + (index << `esize`).
- R8: The destination register receives its value plus the operand. When the destination is also the auto-modified base, the base update is written first, and the final value is (base ± d) + operand.
- R9: A mode code from 10 to 15 raises `err` together with `done` 2 edges after the start edge. It makes no register write and no memory read.
- R10: Modes 2, 3, 4, 5 and 9 raise `done` 4 edges after the start edge. `done` is high for exactly one cycle per operation.
- R11: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its original fields and raises `done` once.
- R12: After reset `done`, `err`, `rf_we` and `mem_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 4 | Addressing-mode code |
| rd_idx | input | 3 | Destination register index |
| rb_idx | input | 3 | Base / source register index |
| rx_idx | input | 3 | Index register index |
| imm | input | 16 | Displacement, immediate or direct address |
| esize | input | 2 | Element size code, d = 1 << esize |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Undefined mode, valid with done |
| rf_b_addr | output | 3 | Read port for base register |
| rf_b_data | input | 16 | Base register value |
| rf_x_addr | output | 3 | Read port for index register |
| rf_x_data | input | 16 | Index register value |
| rf_d_addr | output | 3 | Read port for destination register |
| rf_d_data | input | 16 | Destination register value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory data, valid the cycle after mem_re |

## Verification
The bench targets the ordering modes. If auto-increment and auto-decrement update the base at the wrong moment, they read the wrong word, because each mode runs against a memory that holds distinct values at base and at base ± d. A memory-indirect unit that used the first address twice, or that captured the data a cycle early, would add the pointer word instead of the target word. The bench also aliases the destination onto the auto-modified base, so a unit that wrote the sum before the update would leave only base ± d. Undefined codes, scaled shifts at both size extremes, and a stray `start` during a run are checked for silent register corruption and for duplicate `done` pulses.

// File: rtl/amf_pkg.sv
package amf_pkg;

    typedef enum logic [3:0] {
        M_REG  = 4'd0,
        M_IMM  = 4'd1,
        M_DISP = 4'd2,
        M_RIND = 4'd3,
        M_IDX  = 4'd4,
        M_DIR  = 4'd5,
        M_MIND = 4'd6,
        M_AINC = 4'd7,
        M_ADEC = 4'd8,
        M_SCL  = 4'd9
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ADDR   = 3'd1,
        S_READ1  = 3'd2,
        S_READ2  = 3'd3,
        S_UPDATE = 3'd4,
        S_WB     = 3'd5
    } fsm_e;

    localparam int unsigned MODE_COUNT = 10;

    function automatic logic mode_legal(input logic [3:0] m);
        return (m < 4'(MODE_COUNT));
    endfunction

    function automatic logic mode_no_mem(input logic [3:0] m);
        return (m == M_REG) || (m == M_IMM);
    endfunction

endpackage

// File: rtl/amf_agen.sv
module amf_agen
    import amf_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic [3:0]    mode,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] index,
    input  logic [DW-1:0] imm,
    input  logic [SW-1:0] esz,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] base_up,
    output logic [DW-1:0] base_dn
);
    logic [DW-1:0] step;
    logic [DW-1:0] scaled;

    assign step    = DW'(1) << esz;
    assign scaled  = index << esz;
    assign base_up = base + step;
    assign base_dn = base - step;

    always_comb begin
        case (mode)
            M_DISP:  ea = imm + base;
            M_IDX:   ea = base + index;
            M_DIR:   ea = imm;
            M_SCL:   ea = imm + base + scaled;
            default: ea = base;
        endcase
    end
endmodule

// File: rtl/amf_ctrl.sv
module amf_ctrl
    import amf_pkg::*;
#(
    parameter int DW  = 16,
    parameter int RAW = 3,
    parameter int SW  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [RAW-1:0] rd_idx,
    input  logic [RAW-1:0] rb_idx,
    input  logic [RAW-1:0] rx_idx,
    input  logic [DW-1:0]  imm,
    input  logic [SW-1:0]  esize,
    output logic [3:0]     mode_q,
    output logic [RAW-1:0] rd_q,
    output logic [RAW-1:0] rb_q,
    output logic [RAW-1:0] rx_q,
    output logic [DW-1:0]  imm_q,
    output logic [SW-1:0]  esz_q,
    input  logic [DW-1:0]  ea,
    input  logic [DW-1:0]  base_val,
    input  logic [DW-1:0]  dest_val,
    input  logic [DW-1:0]  base_up,
    input  logic [DW-1:0]  base_dn,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_re,
    output logic [DW-1:0]  mem_addr,
    output logic           rf_we,
    output logic [RAW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata,
    output logic           done,
    output logic           err
);
    fsm_e          state;
    logic          upd_done;
    logic [DW-1:0] opnd;
    logic          legal;
    logic          adec_wait;

    assign legal     = mode_legal(mode_q);
    assign adec_wait = (mode_q == M_ADEC) && !upd_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            upd_done <= 1'b0;
            opnd     <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            mode_q   <= '0;
            rd_q     <= '0;
            rb_q     <= '0;
            rx_q     <= '0;
            imm_q    <= '0;
            esz_q    <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q   <= mode;
                        rd_q     <= rd_idx;
                        rb_q     <= rb_idx;
                        rx_q     <= rx_idx;
                        imm_q    <= imm;
                        esz_q    <= esize;
                        upd_done <= 1'b0;
                        state    <= S_ADDR;
                    end
                end
                S_ADDR: begin
                    if (!legal) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end else if (mode_q == M_REG) begin
                        opnd  <= base_val;
                        state <= S_WB;
                    end else if (mode_q == M_IMM) begin
                        opnd  <= imm_q;
                        state <= S_WB;
                    end else if (adec_wait) begin
                        state <= S_UPDATE;
                    end else begin
                        state <= S_READ1;
                    end
                end
                S_READ1: begin
                    if (mode_q == M_MIND) begin
                        state <= S_READ2;
                    end else begin
                        opnd  <= mem_rdata;
                        state <= (mode_q == M_AINC) ? S_UPDATE : S_WB;
                    end
                end
                S_READ2: begin
                    opnd  <= mem_rdata;
                    state <= S_WB;
                end
                S_UPDATE: begin
                    upd_done <= 1'b1;
                    state    <= (mode_q == M_AINC) ? S_WB : S_ADDR;
                end
                S_WB: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_re   = 1'b0;
        mem_addr = ea;
        if (state == S_ADDR && legal && !mode_no_mem(mode_q) && !adec_wait) begin
            mem_re = 1'b1;
        end else if (state == S_READ1 && mode_q == M_MIND) begin
            mem_re   = 1'b1;
            mem_addr = mem_rdata;
        end
    end

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = rd_q;
        rf_wdata = dest_val + opnd;
        if (state == S_UPDATE) begin
            rf_we    = 1'b1;
            rf_waddr = rb_q;
            rf_wdata = (mode_q == M_AINC) ? base_up : base_dn;
        end else if (state == S_WB) begin
            rf_we = 1'b1;
        end
    end

    // Assertions next to the sequencing they guard
    AST_REG_IMM_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && mode_no_mem(mode_q)) |-> !mem_re); // R1
    AST_MIND_TWO_READS: assert property (@(posedge clk) disable iff (rst)
        (state == S_READ2) |-> ($past(mem_re, 1) && $past(mem_re, 2))); // R4
    AST_AINC_READ_THEN_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (rf_we && state == S_UPDATE && mode_q == M_AINC) |-> $past(state) == S_READ1); // R5
    AST_ADEC_UPDATE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_re && mode_q == M_ADEC) |-> $past(rf_we)); // R6
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADDR && !legal) |-> (!rf_we && !mem_re)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> $stable(mode_q) || $past(state) == S_IDLE); // R11
    AST_NO_READ_WHILE_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> !rf_we); // R8
endmodule

// File: rtl/addr_mode_adder.sv
module addr_mode_adder
    import amf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int SW   = 2,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [RAW-1:0] rd_idx,
    input  logic [RAW-1:0] rb_idx,
    input  logic [RAW-1:0] rx_idx,
    input  logic [DW-1:0]  imm,
    input  logic [SW-1:0]  esize,
    output logic           done,
    output logic           err,
    output logic [RAW-1:0] rf_b_addr,
    input  logic [DW-1:0]  rf_b_data,
    output logic [RAW-1:0] rf_x_addr,
    input  logic [DW-1:0]  rf_x_data,
    output logic [RAW-1:0] rf_d_addr,
    input  logic [DW-1:0]  rf_d_data,
    output logic           rf_we,
    output logic [RAW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata,
    output logic           mem_re,
    output logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata
);
    logic [3:0]     mode_q;
    logic [RAW-1:0] rd_q, rb_q, rx_q;
    logic [DW-1:0]  imm_q;
    logic [SW-1:0]  esz_q;
    logic [DW-1:0]  ea, base_up, base_dn;

    assign rf_b_addr = rb_q;
    assign rf_x_addr = rx_q;
    assign rf_d_addr = rd_q;

    amf_agen #(.DW(DW), .SW(SW)) u_agen (
        .mode    (mode_q),
        .base    (rf_b_data),
        .index   (rf_x_data),
        .imm     (imm_q),
        .esz     (esz_q),
        .ea      (ea),
        .base_up (base_up),
        .base_dn (base_dn)
    );

    amf_ctrl #(.DW(DW), .RAW(RAW), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .rd_idx    (rd_idx),
        .rb_idx    (rb_idx),
        .rx_idx    (rx_idx),
        .imm       (imm),
        .esize     (esize),
        .mode_q    (mode_q),
        .rd_q      (rd_q),
        .rb_q      (rb_q),
        .rx_q      (rx_q),
        .imm_q     (imm_q),
        .esz_q     (esz_q),
        .ea        (ea),
        .base_val  (rf_b_data),
        .dest_val  (rf_d_data),
        .base_up   (base_up),
        .base_dn   (base_dn),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .done      (done),
        .err       (err)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!done && !err && !rf_we && !mem_re)); // R12
endmodule

// File: tb/sim_addr_mode_adder.sv
`timescale 1ns/1ps
module sim_addr_mode_adder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  rd_idx = '0, rb_idx = '0, rx_idx = '0;
    logic [15:0] imm = '0;
    logic [1:0]  esize = '0;
    logic        done, err, rf_we, mem_re;
    logic [2:0]  rf_b_addr, rf_x_addr, rf_d_addr, rf_waddr;
    logic [15:0] rf_b_data, rf_x_data, rf_d_data, rf_wdata, mem_addr;
    logic [15:0] mem_rdata = '0;

    logic [15:0] rf [8];
    logic [15:0] mem [1024];
    int total = 0, fails = 0, reads = 0;

    always #2.5 clk = ~clk;

    assign rf_b_data = rf[rf_b_addr];
    assign rf_x_data = rf[rf_x_addr];
    assign rf_d_data = rf[rf_d_addr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[9:0]];
            reads <= reads + 1;
        end
    end

    addr_mode_adder u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .rd_idx(rd_idx), .rb_idx(rb_idx), .rx_idx(rx_idx),
        .imm(imm), .esize(esize), .done(done), .err(err),
        .rf_b_addr(rf_b_addr), .rf_b_data(rf_b_data),
        .rf_x_addr(rf_x_addr), .rf_x_data(rf_x_data),
        .rf_d_addr(rf_d_addr), .rf_d_data(rf_d_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int lat;
    int nreads;
    logic err_seen;

    task automatic run(input logic [3:0] m, input logic [2:0] d, input logic [2:0] b,
                       input logic [2:0] x, input logic [15:0] k, input logic [1:0] s);
        int r0;
        @(negedge clk);
        mode = m; rd_idx = d; rb_idx = b; rx_idx = x; imm = k; esize = s;
        r0 = reads;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        err_seen = err;
        nreads = reads - r0;
    endtask

    task automatic t_reset;
        check("R12 done after reset", int'(done), 0);
        check("R12 err after reset", int'(err), 0);
        check("R12 rf_we after reset", int'(rf_we), 0);
        check("R12 mem_re after reset", int'(mem_re), 0);
    endtask

    task automatic t_reg_imm;
        rf[3] = 16'd7; rf[4] = 16'd20;
        run(4'd0, 3'd4, 3'd3, 3'd0, 16'd0, 2'd0);
        check("R1 register mode sum", int'(rf[4]), 27);
        check("R1 register mode reads", nreads, 0);
        check("R1 register mode latency", lat, 3);
        run(4'd1, 3'd4, 3'd3, 3'd0, 16'd5, 2'd0);
        check("R1 immediate mode sum", int'(rf[4]), 32);
        check("R1 immediate mode reads", nreads, 0);
    endtask

    task automatic t_disp_ind;
        rf[1] = 16'd100; rf[2] = 16'd200;
        mem[300] = 16'd600; mem[100] = 16'd400; mem[400] = 16'd800;
        run(4'd2, 3'd2, 3'd1, 3'd0, 16'd200, 2'd0);
        check("R2 displacement sum", int'(rf[2]), 800);
        check("R10 displacement latency", lat, 4);
        run(4'd3, 3'd2, 3'd1, 3'd0, 16'd0, 2'd0);
        check("R2 register indirect sum", int'(rf[2]), 1200);
        run(4'd6, 3'd2, 3'd1, 3'd0, 16'd0, 2'd0);
        check("R4 memory indirect sum", int'(rf[2]), 2000);
        check("R4 memory indirect reads", nreads, 2);
        check("R4 memory indirect latency", lat, 5);
    endtask

    task automatic t_idx_dir;
        rf[5] = 16'd30; rf[6] = 16'd40; rf[7] = 16'd1;
        mem[70] = 16'd11; mem[500] = 16'd9;
        run(4'd4, 3'd7, 3'd5, 3'd6, 16'd0, 2'd0);
        check("R3 indexed sum", int'(rf[7]), 12);
        run(4'd5, 3'd7, 3'd5, 3'd6, 16'd500, 2'd0);
        check("R3 direct sum", int'(rf[7]), 21);
        check("R10 direct single read", nreads, 1);
    endtask

    task automatic t_auto;
        rf[1] = 16'd100; rf[2] = 16'd0;
        mem[100] = 16'd400; mem[104] = 16'd3; mem[96] = 16'd33;
        run(4'd7, 3'd2, 3'd1, 3'd0, 16'd0, 2'd2);
        check("R5 autoinc base", int'(rf[1]), 104);
        check("R5 autoinc sum", int'(rf[2]), 400);
        check("R5 autoinc latency", lat, 5);
        run(4'd8, 3'd2, 3'd1, 3'd0, 16'd0, 2'd3);
        check("R6 autodec base", int'(rf[1]), 96);
        check("R6 autodec sum", int'(rf[2]), 433);
        check("R6 autodec latency", lat, 6);
    endtask

    task automatic t_scaled;
        rf[5] = 16'd30; rf[6] = 16'd3; rf[7] = 16'd0;
        mem[154] = 16'd77; mem[133] = 16'd5;
        run(4'd9, 3'd7, 3'd5, 3'd6, 16'd100, 2'd3);
        check("R7 scaled d=8 sum", int'(rf[7]), 77);
        run(4'd9, 3'd7, 3'd5, 3'd6, 16'd100, 2'd0);
        check("R7 scaled d=1 sum", int'(rf[7]), 82);
    endtask

    task automatic t_alias;
        rf[1] = 16'd50; mem[50] = 16'd1000; mem[52] = 16'd7;
        run(4'd7, 3'd1, 3'd1, 3'd0, 16'd0, 2'd1);
        check("R8 dest equals autoinc base", int'(rf[1]), 1052);
        rf[3] = 16'd60; mem[58] = 16'd2; mem[60] = 16'd90;
        run(4'd8, 3'd3, 3'd3, 3'd0, 16'd0, 2'd1);
        check("R8 dest equals autodec base", int'(rf[3]), 60);
    endtask

    task automatic t_illegal;
        logic [15:0] snap [8];
        int same;
        for (int i = 0; i < 8; i++) snap[i] = rf[i];
        run(4'd12, 3'd1, 3'd2, 3'd3, 16'd10, 2'd0);
        check("R9 err with done", int'(err_seen), 1);
        check("R9 latency", lat, 2);
        check("R9 no reads", nreads, 0);
        same = 1;
        for (int i = 0; i < 8; i++) if (rf[i] != snap[i]) same = 0;
        check("R9 registers unchanged", same, 1);
        run(4'd15, 3'd1, 3'd2, 3'd3, 16'd10, 2'd0);
        check("R9 code 15 err", int'(err_seen), 1);
        run(4'd1, 3'd6, 3'd0, 3'd0, 16'd1, 2'd0);
        check("R9 legal op clears err", int'(err_seen), 0);
    endtask

    task automatic t_busy;
        int dones;
        rf[1] = 16'd100; rf[2] = 16'd0; mem[300] = 16'd600;
        @(negedge clk);
        mode = 4'd2; rd_idx = 3'd2; rb_idx = 3'd1; imm = 16'd200; esize = 2'd0;
        start = 1'b1;
        @(negedge clk);
        mode = 4'd1; imm = 16'd9;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check("R11 running op kept fields", int'(rf[2]), 600);
        check("R11 single done", dones, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = '0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reg_imm();
        t_disp_ind();
        t_idx_dir();
        t_auto();
        t_scaled();
        t_alias();
        t_illegal();
        t_busy();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule